// File: doc/BRIEF.md
# Receive Frame Buffer with Byte Readout

This block holds one received network frame for a small memory-mapped network interface. Frame bytes arrive on a byte stream with valid, ready and last. They are written into a local buffer starting at index 0. When the last byte has been stored, the frame is committed. At that point the block loads its remaining-byte counter with the frame length, rewinds its read pointer, marks itself busy and emits a one-cycle receive-done pulse. The external interrupt logic records that pulse in bit 1 of its control word.

Software then empties the frame through a single data register, one byte per read. Each read returns the next byte zero-extended to 32 bits and lowers the remaining count by one. A second register shows how many bytes are left. A new frame is only taken while the busy flag is clear. The busy flag is cleared by the interrupt logic through a release input. Frames of the buffer size or longer are swallowed and leave no trace in the counters, the busy flag or the event.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset the busy flag is set, so `in_ready` is low, `rx_done` is low and the remaining count reads 0.
- R2: In the cycle after `busy_clr` is pulsed, with no frame in progress, `in_ready` is high, because the count is always below the buffer size of 1514.
- R3: When the last byte of a frame of 1 to 1513 bytes is accepted, `rx_done` is high for exactly one cycle, starting one cycle after that beat. From then on, a read of the count register (byte offset 0x0C) returns the frame length.
- R4: A read of the data register (byte offset 0x1C) with a nonzero count returns the next stored byte in arrival order, in bits 7:0 with bits 31:8 zero, on `host_rdata` one cycle after the strobe. It also lowers the count by one.
- R5: A data-register read while the count is 0 returns 0 and leaves the count and the read position unchanged.
- R6: A frame of 1514 bytes or more is consumed in full, with `in_ready` staying high until its last beat. It then leaves the count, the busy flag and `rx_done` as they were.
- R7: An access with `host_wr` high changes neither the count nor the read position. A read of any byte offset other than 0x0C or 0x1C returns 0.
- R8: Once a frame is committed, `in_ready` stays low until `busy_clr` is pulsed, even while `in_valid` is held high.
- R9: If a data-register read falls in the same cycle as a frame commit, the commit wins. That read returns 0, the count becomes the new length, and the next read returns byte 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block can take the presented byte |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (no effect on this block) |
| host_addr | input | 6 | Host byte offset |
| host_rdata | output | 32 | Read data, valid one cycle after the strobe |
| busy_clr | input | 1 | Release of the busy flag from the interrupt logic |
| rx_done | output | 1 | One-cycle receive-done event |

## Verification
Two functions can fall in the same cycle: the commit of a newly arrived frame, and a host read of the data register. The commit rewrites the very count and pointer that the read would step. To provoke the collision, a partly drained frame is left in the buffer and the busy flag is released. A new frame is then streamed, with a data-register strobe raised on the same clock as its last byte. The outcome is judged at the ports. The colliding read must return 0, the count must show the new length, and the following reads must return the new frame from its first byte.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    typedef enum logic [1:0] {
        ING_IDLE  = 2'd0,
        ING_RECV  = 2'd1,
        ING_DRAIN = 2'd2
    } ing_state_e;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DEPTH = 1514,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr] <= wr_byte;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (32'(rd_addr) < DEPTH) begin
            rd_byte = mem_q[rd_addr];
        end
    end
endmodule

// File: rtl/rxb_ingress.sv
module rxb_ingress
    import rxb_pkg::*;
#(
    parameter int MAX_LEN = 1514,
    parameter int CW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          can_take,
    output logic          wr_en,
    output logic [CW-1:0] wr_addr,
    output logic          commit,
    output logic [CW-1:0] commit_len
);
    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_LEN - 1);

    typedef struct packed {
        ing_state_e    st;
        logic [CW-1:0] idx;
    } ing_t;

    ing_t s_d, s_q;
    logic beat;

    always_comb begin
        s_d        = s_q;
        in_ready   = (s_q.st == ING_IDLE) ? can_take : 1'b1;
        beat       = in_valid && in_ready;
        wr_addr    = (s_q.st == ING_IDLE) ? '0 : s_q.idx;
        wr_en      = beat && (s_q.st != ING_DRAIN);
        commit     = 1'b0;
        commit_len = wr_addr + CW'(1);
        if (beat) begin
            unique case (s_q.st)
                ING_IDLE, ING_RECV: begin
                    if (wr_addr == LAST_IDX) begin
                        s_d.st = in_last ? ING_IDLE : ING_DRAIN;
                    end else if (in_last) begin
                        commit = 1'b1;
                        s_d.st = ING_IDLE;
                    end else begin
                        s_d.idx = wr_addr + CW'(1);
                        s_d.st  = ING_RECV;
                    end
                end
                default: begin
                    if (in_last) s_d.st = ING_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ING_IDLE;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_commit_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (32'(commit_len) < MAX_LEN));
    assert_drain_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ING_DRAIN) |-> !commit && !wr_en);
endmodule

// File: rtl/rxb_readout.sv
module rxb_readout #(
    parameter int          MAX_LEN  = 1514,
    parameter int          CW       = 11,
    parameter int          ADW      = 6,
    parameter int          DW       = 32,
    parameter logic [5:0]  OFS_DATA = 6'h1C,
    parameter logic [5:0]  OFS_CNT  = 6'h0C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic [ADW-1:0] host_addr,
    input  logic           busy_clr,
    input  logic           commit,
    input  logic [CW-1:0]  commit_len,
    input  logic [7:0]     rd_byte,
    output logic [CW-1:0]  rd_ptr,
    output logic           can_take,
    output logic [DW-1:0]  host_rdata,
    output logic           rx_done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] ptr;
        logic          busy;
        logic          done;
        logic [DW-1:0] rdata;
    } ro_t;

    ro_t r_d, r_q;
    logic data_hit, cnt_hit;

    always_comb begin
        data_hit  = host_rd && !host_wr && (host_addr == ADW'(OFS_DATA));
        cnt_hit   = host_rd && !host_wr && (host_addr == ADW'(OFS_CNT));
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.rdata = '0;
        if (commit) begin
            r_d.cnt  = commit_len;
            r_d.ptr  = '0;
            r_d.busy = 1'b1;
            r_d.done = 1'b1;
        end else begin
            if (busy_clr) r_d.busy = 1'b0;
            if (data_hit && (r_q.cnt != '0)) begin
                r_d.rdata = DW'(rd_byte);
                r_d.ptr   = r_q.ptr + CW'(1);
                r_d.cnt   = r_q.cnt - CW'(1);
            end else if (cnt_hit) begin
                r_d.rdata = DW'(r_q.cnt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt   <= '0;
            r_q.ptr   <= '0;
            r_q.busy  <= 1'b1;
            r_q.done  <= 1'b0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ptr     = r_q.ptr;
    assign can_take   = !r_q.busy && (32'(r_q.cnt) < MAX_LEN);
    assign host_rdata = r_q.rdata;
    assign rx_done    = r_q.done;

    assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && (r_q.cnt != '0) && !commit) |=>
            (r_q.cnt == $past(r_q.cnt) - CW'(1)) && (r_q.ptr == $past(r_q.ptr) + CW'(1)));
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && (r_q.cnt == '0) && !commit) |=> (r_q.rdata == '0) && $stable(r_q.ptr));
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    assert_commit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (r_q.ptr == '0) && r_q.busy && (r_q.rdata == '0));
    assert_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !commit) |=> $stable(r_q.cnt) && $stable(r_q.ptr));
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
    parameter int MAX_LEN = 1514,
    parameter int ADW     = 6,
    parameter int DW      = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     in_data,
    input  logic           in_last,
    output logic           in_ready,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic [ADW-1:0] host_addr,
    output logic [DW-1:0]  host_rdata,
    input  logic           busy_clr,
    output logic           rx_done
);
    localparam int CW = $clog2(MAX_LEN + 1);

    logic          can_take, wr_en, commit;
    logic [CW-1:0] wr_addr, commit_len, rd_ptr;
    logic [7:0]    rd_byte;

    rxb_store #(.DEPTH(MAX_LEN), .AW(CW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(in_data),
        .rd_addr(rd_ptr), .rd_byte(rd_byte)
    );

    rxb_ingress #(.MAX_LEN(MAX_LEN), .CW(CW)) u_ingress (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .can_take(can_take), .wr_en(wr_en),
        .wr_addr(wr_addr), .commit(commit), .commit_len(commit_len)
    );

    rxb_readout #(.MAX_LEN(MAX_LEN), .CW(CW), .ADW(ADW), .DW(DW)) u_readout (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .busy_clr(busy_clr), .commit(commit),
        .commit_len(commit_len), .rd_byte(rd_byte), .rd_ptr(rd_ptr),
        .can_take(can_take), .host_rdata(host_rdata), .rx_done(rx_done)
    );
endmodule

// File: tb/rx_frame_buffer_bench.sv
`timescale 1ns/1ps
module rx_frame_buffer_bench;
    localparam int MAXL = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0]  in_data = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0, busy_clr = 1'b0, rx_done;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_rdata;

    int    n_checks = 0, n_fails = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  pend = 1'b0;
    bit    done_flag = 1'b0;

    always #2 clk = ~clk;

    rx_frame_buffer u_rx_frame_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_rdata(host_rdata),
        .busy_clr(busy_clr), .rx_done(rx_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: one cycle after each read strobe, compare against the queue
    always @(posedge clk) pend <= host_rd && rst_n;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(host_rdata), exp_q.pop_front());
            end
        end
    end

    function automatic int pat(input int seed, input int i);
        return (seed + i * 7) & 8'hFF;
    endfunction

    task automatic host_read(input logic [5:0] a, input int exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [5:0] a);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic release_busy();
        @(negedge clk);
        busy_clr = 1'b1;
        @(negedge clk);
        busy_clr = 1'b0;
    endtask

    // collide: raise a data read on the same clock as the last beat
    task automatic send_frame(input int len, input int seed, input bit collide);
        int i = 0;
        while (i < len) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(pat(seed, i));
            in_last  = (i == len - 1);
            if (collide && (i == len - 1) && in_ready) begin
                host_rd = 1'b1; host_addr = 6'h1C;
                exp_q.push_back(0); tag_q.push_back("R9 colliding read");
            end
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(in_ready), 0);
        check("R1 rx_done after reset", int'(rx_done), 0);
        host_read(6'h0C, 0, "R1 count after reset");
        host_read(6'h1C, 0, "R5 data read at zero count after reset");

        release_busy();
        check("R2 ready after release", int'(in_ready), 1);

        // frame A, 6 bytes
        send_frame(6, 8'h10, 1'b0);
        check("R3 rx_done pulse", int'(rx_done), 1);
        check("R8 ready low after commit", int'(in_ready), 0);
        @(negedge clk);
        check("R3 rx_done single cycle", int'(rx_done), 0);
        in_valid = 1'b1; in_data = 8'hEE;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 ready held low while busy", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        host_read(6'h0C, 6, "R3 count equals length");
        host_read(6'h1C, pat(8'h10, 0), "R4 byte 0");
        host_read(6'h1C, pat(8'h10, 1), "R4 byte 1");
        host_read(6'h0C, 4, "R4 count after two reads");
        host_write(6'h0C);
        host_write(6'h1C);
        host_read(6'h0C, 4, "R7 count after writes");
        host_read(6'h00, 0, "R7 other offset reads zero");
        for (int k = 2; k < 6; k++) host_read(6'h1C, pat(8'h10, k), "R4 remaining bytes");
        host_read(6'h1C, 0, "R5 read when empty");
        host_read(6'h0C, 0, "R5 count stays zero");

        // oversized frames
        release_busy();
        send_frame(MAXL, 8'h33, 1'b0);
        check("R6 no rx_done for 1514 bytes", int'(rx_done), 0);
        check("R6 ready stays high", int'(in_ready), 1);
        host_read(6'h0C, 0, "R6 count unchanged 1514");
        send_frame(1600, 8'h44, 1'b0);
        check("R6 no rx_done for 1600 bytes", int'(rx_done), 0);
        host_read(6'h0C, 0, "R6 count unchanged 1600");

        // frame D partly drained, then rejection with a nonzero count
        send_frame(3, 8'h50, 1'b0);
        host_read(6'h1C, pat(8'h50, 0), "R4 frame D byte 0");
        release_busy();
        send_frame(MAXL, 8'h60, 1'b0);
        check("R6 no rx_done with pending bytes", int'(rx_done), 0);
        host_read(6'h0C, 2, "R6 count kept at 2");

        // frame E commits in the same cycle as a data read
        send_frame(4, 8'h70, 1'b1);
        check("R9 rx_done on collision", int'(rx_done), 1);
        host_read(6'h0C, 4, "R9 count is new length");
        for (int k = 0; k < 4; k++) host_read(6'h1C, pat(8'h70, k), "R9 new frame from byte 0");

        // largest accepted frame
        release_busy();
        send_frame(MAXL - 1, 8'h81, 1'b0);
        check("R3 rx_done for 1513 bytes", int'(rx_done), 1);
        host_read(6'h0C, MAXL - 1, "R3 count 1513");
        for (int k = 0; k < MAXL - 1; k++) host_read(6'h1C, pat(8'h81, k), "R4 long frame bytes");
        host_read(6'h1C, 0, "R5 read after long frame drained");

        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule